// File: doc/BRIEF.md
# L1 Miss Replay Queue Controller

This block sits between a load/store unit and a set-associative L1 data cache whose outstanding misses are tracked by miss status holding registers (MSHRs). Each cycle it selects at most one request, presents its set index and tag to the cache's tag compare, and acts on the hit/miss answer. A hit produces a response. A miss that can get an MSHR is forwarded to the miss path.

When a miss arrives and no MSHR is free, the block does not stall the load/store unit. It moves the request aside into a small replay queue. Younger requests keep flowing, and those that hit are answered at once while the older miss waits. Whenever an MSHR is free and the queue is not empty, the oldest parked request is replayed ahead of new traffic. A replay that now hits returns a response. A replay that still misses takes the free MSHR. Either way the entry leaves the queue.

A new request from the same warp to the same cache line as a parked request goes into the queue behind it without being looked up. This keeps that warp's accesses to the line in program order.

Top module: `l1_replay_ctrl`

## Requirements
- R1: While and right after reset, `resp_valid` and `miss_valid` are low and `req_ready` is high.
- R2: A new request that hits produces `resp_valid` with its warp and address on the cycle after it is accepted.
- R3: A new request that misses while `mshr_avail` is high is forwarded on `miss_valid`, with its warp and address, on the cycle after acceptance.
- R4: A new request that misses while `mshr_avail` is low produces no response and no miss; it is parked in the replay queue.
- R5: While parked entries wait and `mshr_avail` is low, `req_ready` stays high and hits from new requests are answered at once, ahead of the parked misses.
- R6: While the queue is non-empty and `mshr_avail` is high, the head entry is replayed every cycle and `req_ready` is low, so no new request is taken until the queue drains.
- R7: A replayed entry leaves the queue. It produces a response if it now hits, and otherwise a miss.
- R8: Parked entries are replayed in the order they were parked.
- R9: The queue holds `QDEPTH` entries (default 8). When it is full, `req_ready` is low and no entry is lost.
- R10: A new request whose warp and line (address bits above the offset) match a parked entry is parked without a lookup, even if its line is now resident. A request from another warp to that line is looked up normally.
- R11: The address splits into the byte offset (bits [5:0] by default, for 64-byte lines), the set index (the next 6 bits, for 64 sets) and the tag (the remaining upper bits). These are driven on `lkp_index` and `lkp_tag`.
- R12: `resp_valid` and `miss_valid` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | New request present |
| req_ready | output | 1 | New request accepted this cycle when valid |
| req_warp | input | WARP_W | Warp number of the new request |
| req_addr | input | ADDR_W | Byte address of the new request |
| lkp_valid | output | 1 | A tag lookup is presented this cycle |
| lkp_index | output | INDEX_W | Set index of the lookup |
| lkp_tag | output | TAG_W | Tag of the lookup |
| lkp_hit | input | 1 | Same-cycle hit answer from the cache tag compare |
| mshr_avail | input | 1 | At least one MSHR can take a miss this cycle |
| resp_valid | output | 1 | Hit response |
| resp_warp | output | WARP_W | Warp of the hit response |
| resp_addr | output | ADDR_W | Address of the hit response |
| miss_valid | output | 1 | Miss forwarded to the miss path |
| miss_warp | output | WARP_W | Warp of the forwarded miss |
| miss_addr | output | ADDR_W | Address of the forwarded miss |

## Verification
The bench parks a miss and then makes its line resident before sending a younger access from the same warp to that line. A design that skipped the ordering check would answer the younger access first and break the expected order. An access from another warp to the same line must still be answered at once, which catches a match that ignores the warp number. The bench fills the queue to its depth and checks that ready drops; a queue that overflowed would lose a forwarded miss. It then holds a hit request while MSHRs free up, and expects all eight replays before that hit, which exposes a design that lets new traffic overtake replays or that replays out of order.

// File: rtl/l1rq_pkg.sv
package l1rq_pkg;

  // Decision taken for the request selected in the current cycle
  typedef enum logic [1:0] {
    ACT_IDLE = 2'd0,
    ACT_RESP = 2'd1,
    ACT_MISS = 2'd2,
    ACT_PARK = 2'd3
  } act_e;

endpackage

// File: rtl/l1rq_store.sv
// Replay queue: circular storage plus a parallel warp/line match over all entries.
module l1rq_store #(
  parameter int WARP_W   = 6,
  parameter int ADDR_W   = 32,
  parameter int OFFSET_W = 6,
  parameter int DEPTH    = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic [WARP_W-1:0]          push_warp,
  input  logic [ADDR_W-1:0]          push_addr,
  input  logic                       pop,
  input  logic [WARP_W-1:0]          probe_warp,
  input  logic [ADDR_W-OFFSET_W-1:0] probe_line,
  output logic                       probe_hit,
  output logic                       empty,
  output logic                       full,
  output logic [WARP_W-1:0]          head_warp,
  output logic [ADDR_W-1:0]          head_addr
);

  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [WARP_W-1:0] ent_warp [DEPTH];
  logic [ADDR_W-1:0] ent_addr [DEPTH];
  logic [DEPTH-1:0]  ent_vld;
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  cnt;
  logic [DEPTH-1:0]  match_vec;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  // Payload storage without reset
  always_ff @(posedge clk) begin
    if (push) begin
      ent_warp[wr_ptr] <= push_warp;
      ent_addr[wr_ptr] <= push_addr;
    end
  end

  // Control state
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      cnt     <= '0;
      ent_vld <= '0;
    end else begin
      if (push) begin
        ent_vld[wr_ptr] <= 1'b1;
        wr_ptr          <= bump(wr_ptr);
      end
      if (pop) begin
        ent_vld[rd_ptr] <= 1'b0;
        rd_ptr          <= bump(rd_ptr);
      end
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign empty     = (cnt == '0);
  assign full      = (cnt == CNT_W'(DEPTH));
  assign head_warp = ent_warp[rd_ptr];
  assign head_addr = ent_addr[rd_ptr];

  // One comparator per entry: same warp and same cache line
  for (genvar i = 0; i < DEPTH; i++) begin : g_match
    assign match_vec[i] = ent_vld[i]
                        && (ent_warp[i] == probe_warp)
                        && (ent_addr[i][ADDR_W-1:OFFSET_W] == probe_line);
  end
  assign probe_hit = |match_vec;

  // R9: a push never lands on a full queue
  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);

  // R7: a replay only pops a real entry
  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);

  // R9: the occupancy counter agrees with the per-entry valid bits
  assert_count_match_R9: assert property (@(posedge clk) disable iff (rst)
    $countones(ent_vld) == int'(cnt));

endmodule

// File: rtl/l1rq_select.sv
// Per-cycle arbitration between a replay and a new request, and the action taken.
module l1rq_select
  import l1rq_pkg::*;
#(
  parameter int WARP_W = 6,
  parameter int ADDR_W = 32
) (
  input  logic              q_empty,
  input  logic              q_full,
  input  logic              mshr_avail,
  input  logic              req_valid,
  input  logic [WARP_W-1:0] req_warp,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WARP_W-1:0] head_warp,
  input  logic [ADDR_W-1:0] head_addr,
  input  logic              line_pending,
  input  logic              lkp_hit,
  output logic              req_ready,
  output logic              lkp_valid,
  output logic [WARP_W-1:0] sel_warp,
  output logic [ADDR_W-1:0] sel_addr,
  output act_e              act,
  output logic              do_push,
  output logic              do_pop
);

  logic replay;
  logic take_new;

  assign replay    = !q_empty && mshr_avail;
  assign req_ready = !q_full && !replay;
  assign take_new  = req_valid && req_ready;

  assign sel_warp  = replay ? head_warp : req_warp;
  assign sel_addr  = replay ? head_addr : req_addr;
  assign lkp_valid = replay || (take_new && !line_pending);

  always_comb begin
    act = ACT_IDLE;
    if (replay) begin
      act = lkp_hit ? ACT_RESP : ACT_MISS;
    end else if (take_new) begin
      if (line_pending)    act = ACT_PARK;
      else if (lkp_hit)    act = ACT_RESP;
      else if (mshr_avail) act = ACT_MISS;
      else                 act = ACT_PARK;
    end
  end

  assign do_pop  = replay;
  assign do_push = take_new && (act == ACT_PARK);

endmodule

// File: rtl/l1rq_outreg.sv
// Registered response and miss-path outputs.
module l1rq_outreg
  import l1rq_pkg::*;
#(
  parameter int WARP_W = 6,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  act_e              act,
  input  logic [WARP_W-1:0] sel_warp,
  input  logic [ADDR_W-1:0] sel_addr,
  output logic              resp_valid,
  output logic [WARP_W-1:0] resp_warp,
  output logic [ADDR_W-1:0] resp_addr,
  output logic              miss_valid,
  output logic [WARP_W-1:0] miss_warp,
  output logic [ADDR_W-1:0] miss_addr
);

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      miss_valid <= 1'b0;
    end else begin
      resp_valid <= (act == ACT_RESP);
      miss_valid <= (act == ACT_MISS);
    end
  end

  always_ff @(posedge clk) begin
    if (act == ACT_RESP) begin
      resp_warp <= sel_warp;
      resp_addr <= sel_addr;
    end
    if (act == ACT_MISS) begin
      miss_warp <= sel_warp;
      miss_addr <= sel_addr;
    end
  end

endmodule

// File: rtl/l1_replay_ctrl.sv
// L1 miss replay queue controller (top).
module l1_replay_ctrl
  import l1rq_pkg::*;
#(
  parameter int WARP_W     = 6,
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int SETS       = 64,
  parameter int QDEPTH     = 8,
  localparam int OFFSET_W  = $clog2(LINE_BYTES),
  localparam int INDEX_W   = $clog2(SETS),
  localparam int TAG_W     = ADDR_W - OFFSET_W - INDEX_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [WARP_W-1:0]  req_warp,
  input  logic [ADDR_W-1:0]  req_addr,
  output logic               lkp_valid,
  output logic [INDEX_W-1:0] lkp_index,
  output logic [TAG_W-1:0]   lkp_tag,
  input  logic               lkp_hit,
  input  logic               mshr_avail,
  output logic               resp_valid,
  output logic [WARP_W-1:0]  resp_warp,
  output logic [ADDR_W-1:0]  resp_addr,
  output logic               miss_valid,
  output logic [WARP_W-1:0]  miss_warp,
  output logic [ADDR_W-1:0]  miss_addr
);

  logic              q_empty, q_full, q_match;
  logic              do_push, do_pop;
  logic [WARP_W-1:0] head_warp, sel_warp;
  logic [ADDR_W-1:0] head_addr, sel_addr;
  act_e              act;

  l1rq_store #(
    .WARP_W(WARP_W), .ADDR_W(ADDR_W), .OFFSET_W(OFFSET_W), .DEPTH(QDEPTH)
  ) u_store (
    .clk        (clk),
    .rst        (rst),
    .push       (do_push),
    .push_warp  (req_warp),
    .push_addr  (req_addr),
    .pop        (do_pop),
    .probe_warp (req_warp),
    .probe_line (req_addr[ADDR_W-1:OFFSET_W]),
    .probe_hit  (q_match),
    .empty      (q_empty),
    .full       (q_full),
    .head_warp  (head_warp),
    .head_addr  (head_addr)
  );

  l1rq_select #(
    .WARP_W(WARP_W), .ADDR_W(ADDR_W)
  ) u_select (
    .q_empty      (q_empty),
    .q_full       (q_full),
    .mshr_avail   (mshr_avail),
    .req_valid    (req_valid),
    .req_warp     (req_warp),
    .req_addr     (req_addr),
    .head_warp    (head_warp),
    .head_addr    (head_addr),
    .line_pending (q_match),
    .lkp_hit      (lkp_hit),
    .req_ready    (req_ready),
    .lkp_valid    (lkp_valid),
    .sel_warp     (sel_warp),
    .sel_addr     (sel_addr),
    .act          (act),
    .do_push      (do_push),
    .do_pop       (do_pop)
  );

  // R11: address split for the tag compare
  assign lkp_index = sel_addr[OFFSET_W +: INDEX_W];
  assign lkp_tag   = sel_addr[ADDR_W-1 -: TAG_W];

  l1rq_outreg #(
    .WARP_W(WARP_W), .ADDR_W(ADDR_W)
  ) u_out (
    .clk        (clk),
    .rst        (rst),
    .act        (act),
    .sel_warp   (sel_warp),
    .sel_addr   (sel_addr),
    .resp_valid (resp_valid),
    .resp_warp  (resp_warp),
    .resp_addr  (resp_addr),
    .miss_valid (miss_valid),
    .miss_warp  (miss_warp),
    .miss_addr  (miss_addr)
  );

  // R12: one result per cycle at most
  assert_one_output_R12: assert property (@(posedge clk) disable iff (rst)
    !(resp_valid && miss_valid));

  // R3: a miss only leaves when an MSHR was available
  assert_miss_needs_mshr_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(miss_valid) |-> $past(mshr_avail));

  // R4: an accepted miss without an MSHR yields nothing next cycle
  assert_park_silent_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !mshr_avail && !lkp_hit) |=> (!resp_valid && !miss_valid));

  // R6: a pending replay always produces a result next cycle
  assert_replay_output_R6: assert property (@(posedge clk) disable iff (rst)
    (!q_empty && mshr_avail) |=> (resp_valid || miss_valid));

endmodule

// File: tb/l1_replay_ctrl_tb.sv
module l1_replay_ctrl_tb;

  localparam int WW = 6;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst;
  logic          req_valid, req_ready;
  logic [WW-1:0] req_warp;
  logic [AW-1:0] req_addr;
  logic          lkp_valid, lkp_hit;
  logic [5:0]    lkp_index;
  logic [19:0]   lkp_tag;
  logic          mshr_avail;
  logic          resp_valid, miss_valid;
  logic [WW-1:0] resp_warp, miss_warp;
  logic [AW-1:0] resp_addr, miss_addr;

  always #2 clk = ~clk;   // 250 MHz

  l1_replay_ctrl u_dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_warp(req_warp), .req_addr(req_addr),
    .lkp_valid(lkp_valid), .lkp_index(lkp_index), .lkp_tag(lkp_tag), .lkp_hit(lkp_hit),
    .mshr_avail(mshr_avail),
    .resp_valid(resp_valid), .resp_warp(resp_warp), .resp_addr(resp_addr),
    .miss_valid(miss_valid), .miss_warp(miss_warp), .miss_addr(miss_addr)
  );

  // Cache tag model: a few resident lines
  logic [25:0] res_line [8];
  logic [7:0]  res_v;
  always_comb begin
    lkp_hit = 1'b0;
    for (int i = 0; i < 8; i++)
      if (lkp_valid && res_v[i] && res_line[i] == {lkp_tag, lkp_index}) lkp_hit = 1'b1;
  end

  int nchk = 0;
  int nbad = 0;
  bit run  = 0;
  bit done = 0;

  // Scoreboard: kind 1 = response, 2 = miss
  int      exp_kind [$];
  int      exp_warp [$];
  int      exp_addr [$];
  string   exp_tag  [$];

  task automatic chk(input bit ok, input string tag, input longint got, input longint exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic expect_ev(input int kind, input int w, input logic [AW-1:0] a, input string tag);
    exp_kind.push_back(kind);
    exp_warp.push_back(w);
    exp_addr.push_back(int'(a));
    exp_tag.push_back(tag);
  endtask

  task automatic make_resident(input int slot, input logic [AW-1:0] a);
    res_line[slot] = a[31:6];
    res_v[slot]    = 1'b1;
  endtask

  task automatic send(input int w, input logic [AW-1:0] a);
    @(negedge clk);
    req_valid = 1'b1;
    req_warp  = WW'(w);
    req_addr  = a;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    if (lkp_valid) begin
      chk(lkp_index == a[11:6], "R11 index", lkp_index, a[11:6]);
      chk(lkp_tag == a[31:12], "R11 tag", lkp_tag, a[31:12]);
    end
    @(posedge clk);
    #1;
    req_valid = 1'b0;
  endtask

  // Monitor
  always @(negedge clk) begin
    if (run && !rst && (resp_valid || miss_valid)) begin
      int kind;
      int w;
      int a;
      string t;
      chk(!(resp_valid && miss_valid), "R12 both outputs", {resp_valid, miss_valid}, 0);
      kind = resp_valid ? 1 : 2;
      w    = resp_valid ? int'(resp_warp) : int'(miss_warp);
      a    = resp_valid ? int'(resp_addr) : int'(miss_addr);
      if (exp_kind.size() == 0) begin
        chk(1'b0, "R4 unexpected output", a, 0);
      end else begin
        t = exp_tag.pop_front();
        chk(exp_kind[0] == kind, {t, " kind"}, kind, exp_kind[0]);
        chk(exp_warp[0] == w, {t, " warp"}, w, exp_warp[0]);
        chk(exp_addr[0] == a, {t, " addr"}, a, exp_addr[0]);
        void'(exp_kind.pop_front());
        void'(exp_warp.pop_front());
        void'(exp_addr.pop_front());
      end
    end
  end

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++;
      nbad++;
      $display("FAIL watchdog expired got=0 exp=1");
      finish_run();
    end
  end

  initial begin
    logic [AW-1:0] a_c;
    rst        = 1'b1;
    req_valid  = 1'b0;
    req_warp   = '0;
    req_addr   = '0;
    mshr_avail = 1'b1;
    res_v      = '0;
    for (int i = 0; i < 8; i++) res_line[i] = '0;
    repeat (3) @(negedge clk);
    chk(!resp_valid && !miss_valid, "R1 outputs in reset", {resp_valid, miss_valid}, 0);
    rst = 1'b0;
    #1;
    chk(!resp_valid, "R1 resp_valid", resp_valid, 0);
    chk(!miss_valid, "R1 miss_valid", miss_valid, 0);
    chk(req_ready, "R1 req_ready", req_ready, 1);
    run = 1'b1;

    // R2: plain hit
    make_resident(0, 32'h0000_1040);
    expect_ev(1, 5, 32'h0000_1040, "R2");
    send(5, 32'h0000_1040);

    // R3: miss with MSHR free
    expect_ev(2, 6, 32'h0000_2080, "R3");
    send(6, 32'h0000_2080);

    // R4: miss with no MSHR parks
    @(negedge clk);
    mshr_avail = 1'b0;
    a_c = 32'h0000_30C0;
    send(1, a_c);
    repeat (3) @(negedge clk);
    #1;
    chk(req_ready, "R5 ready with parked entry", req_ready, 1);

    // R5: hit under parked miss; R10: other warp to same line is looked up
    make_resident(1, 32'h0000_4100);
    expect_ev(1, 3, 32'h0000_4100, "R5");
    send(3, 32'h0000_4100);
    make_resident(2, a_c);
    expect_ev(1, 2, 32'h0000_30C8, "R10 other warp");
    send(2, 32'h0000_30C8);
    // R10: same warp, same line stays behind the parked entry
    send(1, 32'h0000_30D0);
    repeat (4) @(negedge clk);

    // R7/R8: replay, now hitting, in parked order
    expect_ev(1, 1, a_c, "R7 replay hit");
    expect_ev(1, 1, 32'h0000_30D0, "R10 order");
    @(negedge clk);
    mshr_avail = 1'b1;
    repeat (6) @(negedge clk);

    // R9: fill the queue
    mshr_avail = 1'b0;
    for (int i = 0; i < 8; i++)
      expect_ev(2, i, 32'h0001_0000 + 32'(i) * 32'h40, "R8 fifo replay miss");
    for (int i = 0; i < 8; i++)
      send(i, 32'h0001_0000 + 32'(i) * 32'h40);
    @(negedge clk);
    #1;
    chk(!req_ready, "R9 ready low when full", req_ready, 0);

    // R6: replays go before a waiting new hit
    make_resident(3, 32'h0000_5140);
    expect_ev(1, 4, 32'h0000_5140, "R6 new after replays");
    @(negedge clk);
    mshr_avail = 1'b1;
    send(4, 32'h0000_5140);

    repeat (10) @(negedge clk);
    chk(exp_kind.size() == 0, "R6 all expected seen", exp_kind.size(), 0);
    done = 1'b1;
    finish_run();
  end

endmodule